// File: doc/BRIEF.md
# Non-Secure Unit Access Control Register

This block holds a 32-bit control word that decides whether software running in the non-secure world may use the trace unit, the SIMD unit and the floating-point unit. It sits behind a coprocessor-style system register port. For each request the port supplies a decoded selector, the direction, the current privilege level (0 to 3), the security state, and a few configuration inputs. Those inputs describe whether level 2 is enabled and in which mode, the level-2 trap bit for this register group, whether level 3 exists, its mode and its non-secure bit, and a pin that locks secure writes.

In the cycle of the request the block decides one outcome. The outcome is read data, a register update, an undefined-instruction indication, or a trap with a target level and a syndrome code. A fixed priority chain picks the outcome. Exception entry is left to the surrounding core. Two stored controls are driven out so that permission checkers elsewhere can use them: the floating-point/SIMD enable and the SIMD disable.

Top module: `ns_acc_ctl`

## Requirements
- R1: The block claims a request only when `acc_valid` is high and the selector is coprocessor 15, opc1=0, CRn=1, CRm=1, opc2=2. An unclaimed request drives every response output to zero and leaves the stored word unchanged.
- R2: A claimed request at level 0 raises undefined, for both reads and writes.
- R3: At level 1, reads and writes first pass four trap checks, taken in this order. (a) Level 2 enabled, 64-bit, and trap bit set: 64-bit trap to level 2. (b) Level 2 enabled, 32-bit, and trap bit set: hypervisor trap to level 2. (c) Level 2 enabled, 64-bit, and secure state: 64-bit trap to level 2. (d) Level 3 present, 64-bit, and secure state: 64-bit trap to level 3. Every trap carries syndrome 0x03.
- R4: A read at level 1 that passes the checks, or any read at level 2, returns 0x00000C00 when level 3 is absent, or when level 3 is 64-bit with its non-secure bit set. Otherwise it returns the stored word.
- R5: A read at level 3 always returns the stored word.
- R6: A write at level 1 that passes the trap checks raises undefined. A write at level 2 always raises undefined. Neither write changes the stored word.
- R7: A write at level 3 updates the stored word on the next clock edge. When `sec_wr_lock` is high, the write instead raises undefined and the word is unchanged.
- R8: Field layout: bit 20 is the trace disable, bit 15 the SIMD disable, bit 10 the floating-point/SIMD enable. Bit 11 is not stored and reads back the value of bit 10. Every other bit reads zero and ignores writes.
- R9: When parameter `HAS_FPSIMD` is 0, bits 10 and 11 of the stored word read zero, ignore writes, and `ns_fpsimd_en` stays low.
- R10: Reset clears the stored word. `ns_fpsimd_en` and `ns_simd_dis` always follow the stored bits 10 and 15.
- R11: At most one of read-valid, undefined, 64-bit trap and hypervisor trap is high. Each is valid in the same cycle as the request. Target level and syndrome are zero unless a trap is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_coproc | input | 4 | Selector: coprocessor number |
| acc_opc1 | input | 3 | Selector: opc1 |
| acc_crn | input | 4 | Selector: CRn |
| acc_crm | input | 4 | Selector: CRm |
| acc_opc2 | input | 3 | Selector: opc2 |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| cur_lvl | input | 2 | Current privilege level |
| cur_secure | input | 1 | Core is in secure state |
| lvl2_enabled | input | 1 | Level 2 enabled in current state |
| lvl2_is64 | input | 1 | Level 2 runs in 64-bit mode |
| lvl2_trap_t1 | input | 1 | Level-2 trap bit for this register group |
| lvl3_present | input | 1 | Level 3 implemented |
| lvl3_is64 | input | 1 | Level 3 runs in 64-bit mode |
| lvl3_ns | input | 1 | Level-3 non-secure configuration bit |
| sec_wr_lock | input | 1 | Blocks level-3 writes |
| acc_claimed | output | 1 | Request matched this register |
| rsp_rd_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_trap | output | 1 | 64-bit system access trap |
| rsp_hyp_trap | output | 1 | 32-bit hypervisor trap |
| rsp_tgt_lvl | output | 2 | Trap target level |
| rsp_syndrome | output | 6 | Trap syndrome code |
| ns_fpsimd_en | output | 1 | Stored floating-point/SIMD enable |
| ns_simd_dis | output | 1 | Stored SIMD disable |

## Verification
The hardest outcomes to reach are the lower rungs of the level-1 chain. Rung (d) needs level 2 disabled or in 32-bit mode with its trap bit clear, while level 3 is 64-bit and the core is secure. The constant read needs all four rungs inactive and one of the two constant conditions true. Uniform random configuration bits would reach each of these only a few times in a run. Directed accesses therefore set up each rung with every higher rung just switched off. The stored word is first loaded from level 3 so that the constant can be told apart from it. Random traffic then mixes levels, states, selectors and the lock pin, and a second instance built without floating point shares the same inputs.

// File: rtl/ns_acc_pkg.sv
package ns_acc_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned SYN_W       = 6;
    localparam int unsigned POS_TRC     = 20;
    localparam int unsigned POS_SIMD    = 15;
    localparam int unsigned POS_FP      = 10;
    localparam int unsigned POS_FP_MIR  = 11;
    localparam logic [WORD_W-1:0] FIXED_WORD = 32'h0000_0C00;
    localparam logic [SYN_W-1:0]  TRAP_SYN   = 6'h03;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_READ_REG,
        ACT_READ_FIXED,
        ACT_WRITE,
        ACT_UNDEF,
        ACT_TRAP64,
        ACT_TRAP_HYP
    } act_e;

    typedef struct packed {
        logic trc_dis;
        logic simd_dis;
        logic fp_en;
    } ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode #(
    parameter logic [3:0] SEL_COPROC = 4'd15,
    parameter logic [2:0] SEL_OPC1   = 3'd0,
    parameter logic [3:0] SEL_CRN    = 4'd1,
    parameter logic [3:0] SEL_CRM    = 4'd1,
    parameter logic [2:0] SEL_OPC2   = 3'd2
) (
    input  logic       valid,
    input  logic [3:0] coproc,
    input  logic [2:0] opc1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] opc2,
    output logic       hit
);
    always_comb begin
        hit = valid
            && (coproc == SEL_COPROC)
            && (opc1   == SEL_OPC1)
            && (crn    == SEL_CRN)
            && (crm    == SEL_CRM)
            && (opc2   == SEL_OPC2);
    end
endmodule

// File: rtl/acc_arbiter.sv
module acc_arbiter
    import ns_acc_pkg::*;
(
    input  logic       hit,
    input  logic       write,
    input  logic [1:0] lvl,
    input  logic       secure,
    input  logic       l2_en,
    input  logic       l2_64,
    input  logic       l2_t1,
    input  logic       l3_present,
    input  logic       l3_64,
    input  logic       l3_ns,
    input  logic       wr_lock,
    output act_e       act,
    output logic [1:0] tgt
);
    logic fixed_rd;

    always_comb begin
        fixed_rd = !l3_present || (l3_64 && l3_ns);
        act      = ACT_NONE;
        tgt      = 2'd0;
        if (hit) begin
            unique case (lvl)
                2'd0: act = ACT_UNDEF;
                2'd1: begin
                    if (l2_en && l2_64 && l2_t1) begin
                        act = ACT_TRAP64;
                        tgt = 2'd2;
                    end else if (l2_en && !l2_64 && l2_t1) begin
                        act = ACT_TRAP_HYP;
                        tgt = 2'd2;
                    end else if (l2_en && l2_64 && secure) begin
                        act = ACT_TRAP64;
                        tgt = 2'd2;
                    end else if (l3_present && l3_64 && secure) begin
                        act = ACT_TRAP64;
                        tgt = 2'd3;
                    end else if (write) begin
                        act = ACT_UNDEF;
                    end else begin
                        act = fixed_rd ? ACT_READ_FIXED : ACT_READ_REG;
                    end
                end
                2'd2: begin
                    if (write) act = ACT_UNDEF;
                    else       act = fixed_rd ? ACT_READ_FIXED : ACT_READ_REG;
                end
                default: begin
                    if (!write)       act = ACT_READ_REG;
                    else if (wr_lock) act = ACT_UNDEF;
                    else              act = ACT_WRITE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ctl_store.sv
module ctl_store
    import ns_acc_pkg::*;
#(
    parameter bit HAS_FPSIMD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output ctl_t              ctl_q,
    output logic [WORD_W-1:0] rd_word
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.trc_dis  = wdata[POS_TRC];
            ctl_d.simd_dis = wdata[POS_SIMD];
            ctl_d.fp_en    = HAS_FPSIMD ? wdata[POS_FP] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_word             = '0;
        rd_word[POS_TRC]    = ctl_q.trc_dis;
        rd_word[POS_SIMD]   = ctl_q.simd_dis;
        rd_word[POS_FP]     = ctl_q.fp_en;
        rd_word[POS_FP_MIR] = ctl_q.fp_en;
    end
endmodule

// File: rtl/ns_acc_ctl.sv
module ns_acc_ctl
    import ns_acc_pkg::*;
#(
    parameter bit HAS_FPSIMD = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic [3:0]  acc_coproc,
    input  logic [2:0]  acc_opc1,
    input  logic [3:0]  acc_crn,
    input  logic [3:0]  acc_crm,
    input  logic [2:0]  acc_opc2,
    input  logic        acc_write,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  cur_lvl,
    input  logic        cur_secure,
    input  logic        lvl2_enabled,
    input  logic        lvl2_is64,
    input  logic        lvl2_trap_t1,
    input  logic        lvl3_present,
    input  logic        lvl3_is64,
    input  logic        lvl3_ns,
    input  logic        sec_wr_lock,
    output logic        acc_claimed,
    output logic        rsp_rd_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_undef,
    output logic        rsp_trap,
    output logic        rsp_hyp_trap,
    output logic [1:0]  rsp_tgt_lvl,
    output logic [5:0]  rsp_syndrome,
    output logic        ns_fpsimd_en,
    output logic        ns_simd_dis
);
    logic              hit;
    act_e              act;
    logic [1:0]        tgt;
    ctl_t              ctl_q;
    logic [WORD_W-1:0] rd_word;
    logic              trap_any;

    acc_decode u_decode (
        .valid  (acc_valid),
        .coproc (acc_coproc),
        .opc1   (acc_opc1),
        .crn    (acc_crn),
        .crm    (acc_crm),
        .opc2   (acc_opc2),
        .hit    (hit)
    );

    acc_arbiter u_arbiter (
        .hit        (hit),
        .write      (acc_write),
        .lvl        (cur_lvl),
        .secure     (cur_secure),
        .l2_en      (lvl2_enabled),
        .l2_64      (lvl2_is64),
        .l2_t1      (lvl2_trap_t1),
        .l3_present (lvl3_present),
        .l3_64      (lvl3_is64),
        .l3_ns      (lvl3_ns),
        .wr_lock    (sec_wr_lock),
        .act        (act),
        .tgt        (tgt)
    );

    ctl_store #(.HAS_FPSIMD(HAS_FPSIMD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (act == ACT_WRITE),
        .wdata   (acc_wdata),
        .ctl_q   (ctl_q),
        .rd_word (rd_word)
    );

    always_comb begin
        trap_any     = (act == ACT_TRAP64) || (act == ACT_TRAP_HYP);
        acc_claimed  = hit;
        rsp_rd_valid = (act == ACT_READ_REG) || (act == ACT_READ_FIXED);
        rsp_undef    = (act == ACT_UNDEF);
        rsp_trap     = (act == ACT_TRAP64);
        rsp_hyp_trap = (act == ACT_TRAP_HYP);
        rsp_tgt_lvl  = trap_any ? tgt : 2'd0;
        rsp_syndrome = trap_any ? TRAP_SYN : '0;
        unique case (act)
            ACT_READ_REG:   rsp_rdata = rd_word;
            ACT_READ_FIXED: rsp_rdata = FIXED_WORD;
            default:        rsp_rdata = '0;
        endcase
        ns_fpsimd_en = ctl_q.fp_en;
        ns_simd_dis  = ctl_q.simd_dis;
    end
endmodule

// File: rtl/ns_acc_checker.sv
module ns_acc_checker #(
    parameter bit HAS_FPSIMD = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_write,
    input logic [1:0]  cur_lvl,
    input logic        sec_wr_lock,
    input logic        acc_claimed,
    input logic        rsp_rd_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_undef,
    input logic        rsp_trap,
    input logic        rsp_hyp_trap,
    input logic [5:0]  rsp_syndrome,
    input logic        ns_fpsimd_en,
    input logic        ns_simd_dis
);
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_rd_valid, rsp_undef, rsp_trap, rsp_hyp_trap}));

    p_quiet_unclaimed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_claimed |-> !(rsp_rd_valid || rsp_undef || rsp_trap || rsp_hyp_trap)
                         && rsp_rdata == 32'd0);

    p_lvl0_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_claimed && cur_lvl == 2'd0 |-> rsp_undef);

    p_trap_syndrome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap || rsp_hyp_trap) |-> rsp_syndrome == 6'h03);

    p_top_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_claimed && !acc_write && cur_lvl == 2'd3 |-> rsp_rd_valid);

    p_lvl2_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_claimed && acc_write && cur_lvl == 2'd2 |-> rsp_undef);

    p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_claimed && acc_write && cur_lvl == 2'd3 && sec_wr_lock
        |=> $stable(ns_fpsimd_en) && $stable(ns_simd_dis));

    p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rd_valid |-> rsp_rdata[11] == rsp_rdata[10]);

    generate
        if (!HAS_FPSIMD) begin : g_nofp
            p_fp_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !ns_fpsimd_en);
        end
    endgenerate
endmodule

bind ns_acc_ctl ns_acc_checker #(.HAS_FPSIMD(HAS_FPSIMD)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_write    (acc_write),
    .cur_lvl      (cur_lvl),
    .sec_wr_lock  (sec_wr_lock),
    .acc_claimed  (acc_claimed),
    .rsp_rd_valid (rsp_rd_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_undef    (rsp_undef),
    .rsp_trap     (rsp_trap),
    .rsp_hyp_trap (rsp_hyp_trap),
    .rsp_syndrome (rsp_syndrome),
    .ns_fpsimd_en (ns_fpsimd_en),
    .ns_simd_dis  (ns_simd_dis)
);

// File: tb/test_ns_acc_ctl.sv
module test_ns_acc_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_coproc = 4'd15;
    logic [2:0]  acc_opc1 = 3'd0;
    logic [3:0]  acc_crn = 4'd1;
    logic [3:0]  acc_crm = 4'd1;
    logic [2:0]  acc_opc2 = 3'd2;
    logic        acc_write = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  cur_lvl = 2'd3;
    logic        cur_secure = 1'b0;
    logic        lvl2_enabled = 1'b0;
    logic        lvl2_is64 = 1'b0;
    logic        lvl2_trap_t1 = 1'b0;
    logic        lvl3_present = 1'b1;
    logic        lvl3_is64 = 1'b0;
    logic        lvl3_ns = 1'b0;
    logic        sec_wr_lock = 1'b0;

    logic        claimed, rv, ud, tr, hy, fpe, sdis;
    logic [31:0] rd;
    logic [1:0]  tg;
    logic [5:0]  sy;
    logic        n_claimed, n_rv, n_ud, n_tr, n_hy, n_fpe, n_sdis;
    logic [31:0] n_rd;
    logic [1:0]  n_tg;
    logic [5:0]  n_sy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit m_trc, m_simd, m_fp;

    always #5 clk = ~clk;

    ns_acc_ctl i_ns_acc_ctl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .acc_coproc(acc_coproc), .acc_opc1(acc_opc1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .cur_lvl(cur_lvl), .cur_secure(cur_secure),
        .lvl2_enabled(lvl2_enabled), .lvl2_is64(lvl2_is64),
        .lvl2_trap_t1(lvl2_trap_t1), .lvl3_present(lvl3_present),
        .lvl3_is64(lvl3_is64), .lvl3_ns(lvl3_ns), .sec_wr_lock(sec_wr_lock),
        .acc_claimed(claimed), .rsp_rd_valid(rv), .rsp_rdata(rd),
        .rsp_undef(ud), .rsp_trap(tr), .rsp_hyp_trap(hy),
        .rsp_tgt_lvl(tg), .rsp_syndrome(sy),
        .ns_fpsimd_en(fpe), .ns_simd_dis(sdis)
    );

    ns_acc_ctl #(.HAS_FPSIMD(1'b0)) i_ns_acc_ctl_nofp (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .acc_coproc(acc_coproc), .acc_opc1(acc_opc1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .cur_lvl(cur_lvl), .cur_secure(cur_secure),
        .lvl2_enabled(lvl2_enabled), .lvl2_is64(lvl2_is64),
        .lvl2_trap_t1(lvl2_trap_t1), .lvl3_present(lvl3_present),
        .lvl3_is64(lvl3_is64), .lvl3_ns(lvl3_ns), .sec_wr_lock(sec_wr_lock),
        .acc_claimed(n_claimed), .rsp_rd_valid(n_rv), .rsp_rdata(n_rd),
        .rsp_undef(n_ud), .rsp_trap(n_tr), .rsp_hyp_trap(n_hy),
        .rsp_tgt_lvl(n_tg), .rsp_syndrome(n_sy),
        .ns_fpsimd_en(n_fpe), .ns_simd_dis(n_sdis)
    );

    typedef struct {
        bit        hit;
        bit        rv;
        bit [31:0] rd;
        bit        fixed;
        bit        ud;
        bit        tr;
        bit        hy;
        bit [1:0]  tg;
        bit        wr;
    } exp_t;

    function automatic bit [31:0] model_word(bit fp_ok);
        bit [31:0] w = '0;
        w[20] = m_trc;
        w[15] = m_simd;
        w[10] = m_fp && fp_ok;
        w[11] = m_fp && fp_ok;
        return w;
    endfunction

    function automatic exp_t predict();
        exp_t e = '{default: '0};
        bit const_rd = !lvl3_present || (lvl3_is64 && lvl3_ns);
        e.hit = acc_valid && acc_coproc == 4'd15 && acc_opc1 == 3'd0 &&
                acc_crn == 4'd1 && acc_crm == 4'd1 && acc_opc2 == 3'd2;
        if (!e.hit) return e;
        if (cur_lvl == 2'd0) begin
            e.ud = 1'b1;
            return e;
        end
        if (cur_lvl == 2'd1) begin
            if (lvl2_enabled && lvl2_is64 && lvl2_trap_t1) begin e.tr = 1; e.tg = 2; return e; end
            if (lvl2_enabled && !lvl2_is64 && lvl2_trap_t1) begin e.hy = 1; e.tg = 2; return e; end
            if (lvl2_enabled && lvl2_is64 && cur_secure) begin e.tr = 1; e.tg = 2; return e; end
            if (lvl3_present && lvl3_is64 && cur_secure) begin e.tr = 1; e.tg = 3; return e; end
        end
        if (cur_lvl == 2'd3) begin
            if (!acc_write) begin e.rv = 1; e.rd = model_word(1'b1); end
            else if (sec_wr_lock) e.ud = 1;
            else e.wr = 1;
            return e;
        end
        if (acc_write) begin e.ud = 1; return e; end
        e.rv = 1;
        e.fixed = const_rd;
        e.rd = const_rd ? 32'h0000_0C00 : model_word(1'b1);
        return e;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = 1'b1;
        #1;
        e = predict();
        check(tag, "claimed", 64'(claimed), 64'(e.hit));
        check(tag, "response", {rv, ud, tr, hy, tg, sy, rd},
              {e.rv, e.ud, e.tr, e.hy, e.tg, ((e.tr || e.hy) ? 6'h03 : 6'h00), e.rd});
        check({tag, "/R10"}, "exported", {fpe, sdis}, {m_fp, m_simd});
        check({tag, "/R9"}, "nofp", {n_rv, n_rd, n_fpe},
              {e.rv, (e.fixed ? 32'h0000_0C00 : (e.rd & ~32'h0000_0C00)), 1'b0});
        @(posedge clk);
        if (e.wr) begin
            m_trc  = acc_wdata[20];
            m_simd = acc_wdata[15];
            m_fp   = acc_wdata[10];
        end
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic set_cfg(bit [1:0] lvl, bit wr, bit sec, bit l2e, bit l2w, bit t1,
                           bit l3p, bit l3w, bit l3n, bit lock);
        cur_lvl = lvl; acc_write = wr; cur_secure = sec;
        lvl2_enabled = l2e; lvl2_is64 = l2w; lvl2_trap_t1 = t1;
        lvl3_present = l3p; lvl3_is64 = l3w; lvl3_ns = l3n; sec_wr_lock = lock;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0451));
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset word", {31'd0, fpe, sdis}, 33'd0);
        rst_n = 1'b1;

        // R10: reset value visible at level 3
        set_cfg(3, 0, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R10");
        // R7/R8: load all ones; only bits 20,15,10 stored, bit 11 mirrors 10
        acc_wdata = 32'hFFFF_FFFF;
        set_cfg(3, 1, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R7");
        set_cfg(3, 0, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R8");
        // R8: bit 11 set with bit 10 clear reads back as zero
        acc_wdata = 32'h0000_0800;
        set_cfg(3, 1, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R8");
        set_cfg(3, 0, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R8");
        acc_wdata = 32'h0010_8400;
        set_cfg(3, 1, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R7");
        // R7: locked write is undefined and leaves the word
        acc_wdata = 32'h0;
        set_cfg(3, 1, 1, 0, 0, 0, 1, 0, 0, 1);
        apply("R7");
        set_cfg(3, 0, 1, 0, 0, 0, 1, 0, 0, 1);
        apply("R5");
        // R2
        set_cfg(0, 0, 0, 1, 1, 1, 1, 1, 1, 0);
        apply("R2");
        set_cfg(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        apply("R2");
        // R3 rungs, each with higher rungs just inactive
        set_cfg(1, 0, 1, 1, 1, 1, 1, 1, 0, 0);
        apply("R3");
        set_cfg(1, 1, 1, 1, 0, 1, 1, 1, 0, 0);
        apply("R3");
        set_cfg(1, 0, 1, 1, 1, 0, 1, 1, 0, 0);
        apply("R3");
        set_cfg(1, 1, 1, 1, 0, 0, 1, 1, 0, 0);
        apply("R3");
        set_cfg(1, 0, 1, 0, 1, 1, 1, 1, 0, 0);
        apply("R3");
        // R4: constant versus stored
        set_cfg(1, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        apply("R4");
        set_cfg(1, 0, 0, 0, 0, 0, 1, 1, 1, 0);
        apply("R4");
        set_cfg(1, 0, 1, 0, 0, 0, 1, 0, 1, 0);
        apply("R4");
        set_cfg(2, 0, 0, 1, 1, 0, 1, 1, 1, 0);
        apply("R4");
        set_cfg(2, 0, 1, 1, 1, 0, 1, 1, 0, 0);
        apply("R4");
        // R6
        acc_wdata = 32'h0;
        set_cfg(1, 1, 0, 0, 0, 0, 1, 0, 0, 0);
        apply("R6");
        set_cfg(2, 1, 0, 0, 0, 0, 1, 0, 0, 0);
        apply("R6");
        set_cfg(3, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        apply("R6");
        // R1: wrong selector, level-3 write must not land
        acc_opc2 = 3'd3;
        set_cfg(3, 1, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R1");
        acc_opc2 = 3'd2;
        set_cfg(3, 0, 1, 0, 0, 0, 1, 0, 0, 0);
        apply("R1");

        // R11 and mixed traffic
        for (int i = 0; i < 1500; i++) begin
            bit [3:0] pick = 4'($urandom_range(0, 15));
            acc_coproc = 4'd15; acc_opc1 = 3'd0; acc_crn = 4'd1; acc_crm = 4'd1; acc_opc2 = 3'd2;
            case (pick)
                4'd0: acc_coproc = 4'($urandom_range(0, 14));
                4'd1: acc_opc1   = 3'($urandom_range(1, 7));
                4'd2: acc_crm    = 4'($urandom_range(2, 15));
                default: ;
            endcase
            acc_wdata = $urandom;
            set_cfg(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
            apply("R11");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule